// File: doc/BRIEF.md
# Per-Channel Gain Requantizer

This block sits after a channelizer that emits two adjacent frequency channels per clock, one even-numbered and one odd-numbered. Every complex sample arrives as an 18-bit signed real part and an 18-bit signed imaginary part, read as fractions with 17 fractional bits. The block scales both parts by an unsigned gain chosen for that frequency channel and reduces each product to a signed 4-bit code with 3 fractional bits. The result is a stream of narrow complex values that is cheap to correlate.

Gains live in two on-chip tables, one per lane, indexed by a pair counter. A sync pulse on the clock that carries channels 0 and 1 realigns the counter. A host loads gains through a plain address, data and strobe port. An instance handles one polarization, so the two polarizations of a signal use separate instances, and each can hold its own gain set. Results leave the block a fixed three clocks after their inputs, together with delayed copies of valid and sync.

Top module: `gq_requant`

## Requirements
- R1: While rst_n is low, out_valid and out_sync are 0 and all four data outputs are 0.
- R2: out_valid and out_sync equal in_valid and (in_valid AND in_sync) from exactly 3 clocks earlier, and the data for an input pair appears in that same cycle.
- R3: Each accepted pair (in_valid high) gets a pair index. With in_sync high the index is 0. Otherwise it is the previous index plus one, and it wraps from NCHAN/2-1 to 0. The first pair after reset without sync gets index 0. Cycles with in_valid low do not advance the index.
- R4: cfg_addr holds a frequency channel number. Bit 0 = 0 writes the even table and bit 0 = 1 writes the odd table, at pair address cfg_addr[CAW-1:1]. A pair with index k is scaled by the gain of channel 2k in the even lane and channel 2k+1 in the odd lane.
- R5: Each output part is the nearest integer to d*g/2^22, where d is the signed 18-bit input part and g is the unsigned 16-bit gain. This is the 17-fraction-bit input times the 8-fraction-bit gain, expressed in 3-fraction-bit output steps.
- R6: Exact halfway products round away from zero: +0.5 step gives +1, -0.5 gives -1, +1.5 gives +2, -1.5 gives -2.
- R7: Results clamp symmetrically to the range -7..+7. The code -8 (4'b1000) never appears.
- R8: A gain written while the stream is idle is used by every later sample of that channel, and the rewritten channel's old value no longer appears.
- R9: The real and imaginary parts of one channel use the same gain and are computed independently.
- R10: While out_valid is low, all four data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is present this clock |
| in_sync | input | 1 | Marks the pair carrying channels 0 and 1 |
| in_even_re | input | IN_W | Even channel real part, signed |
| in_even_im | input | IN_W | Even channel imaginary part, signed |
| in_odd_re | input | IN_W | Odd channel real part, signed |
| in_odd_im | input | IN_W | Odd channel imaginary part, signed |
| cfg_we | input | 1 | Gain write strobe |
| cfg_addr | input | CAW | Frequency channel number of the gain written |
| cfg_wdata | input | GAIN_W | Unsigned gain, GAIN_FRAC fractional bits |
| out_valid | output | 1 | Output pair is present |
| out_sync | output | 1 | Output pair carries channels 0 and 1 |
| out_even_re | output | OUT_W | Even channel real code, signed |
| out_even_im | output | OUT_W | Even channel imaginary code, signed |
| out_odd_re | output | OUT_W | Odd channel real code, signed |
| out_odd_im | output | OUT_W | Odd channel imaginary code, signed |

## Verification
The bench builds the block with NCHAN set to 32, so a frame is 16 pairs. Every gain entry can then be loaded with a distinct value. The counter wrap at the end of a frame, a sync arriving mid-frame, and gaps in valid all fit into a few hundred clocks. The sample widths stay at their defaults of 18, 16 and 4 bits, so the rounding ties, the clamp at both ends, the most negative input and the largest gain all reach the real arithmetic.

// File: rtl/gq_pkg.sv
package gq_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_e;
endpackage

// File: rtl/gq_gain_ram.sv
module gq_gain_ram #(
    parameter int DEPTH = 2048,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/gq_pair_ctr.sv
module gq_pair_ctr #(
    parameter int PAIRS = 2048,
    localparam int AW   = $clog2(PAIRS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sync,
    output logic [AW-1:0] rd_idx
);
    typedef struct packed {
        logic [AW-1:0] last;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [AW-1:0] idx_now;

    always_comb begin
        ctr_d = ctr_q;
        if (in_sync) begin
            idx_now = '0;
        end else if (ctr_q.last == AW'(PAIRS - 1)) begin
            idx_now = '0;
        end else begin
            idx_now = ctr_q.last + AW'(1);
        end
        if (in_valid) begin
            ctr_d.last = idx_now;
        end
        rd_idx = idx_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.last <= AW'(PAIRS - 1);
        end else begin
            ctr_q <= ctr_d;
        end
    end
endmodule

// File: rtl/gq_lane.sv
module gq_lane #(
    parameter int IN_W   = 18,
    parameter int GAIN_W = 16,
    parameter int DROP   = 22,
    parameter int OUT_W  = 4,
    localparam int P_W   = IN_W + GAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stg2_vld,
    input  logic signed [IN_W-1:0]   d_re,
    input  logic signed [IN_W-1:0]   d_im,
    input  logic [GAIN_W-1:0]        gain,
    output logic signed [OUT_W-1:0]  q_re,
    output logic signed [OUT_W-1:0]  q_im
);
    localparam logic signed [P_W-1:0] HALF    = P_W'(1) << (DROP - 1);
    localparam logic signed [P_W-1:0] HALF_LO = HALF - P_W'(1);
    localparam logic signed [P_W-1:0] QMAX_P  = P_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [P_W-1:0] QMIN_P  = -QMAX_P;

    typedef struct packed {
        logic signed [P_W-1:0]   p_re;
        logic signed [P_W-1:0]   p_im;
        logic signed [OUT_W-1:0] o_re;
        logic signed [OUT_W-1:0] o_im;
    } lane_t;

    lane_t st_d, st_q;

    function automatic logic signed [OUT_W-1:0] requant(input logic signed [P_W-1:0] p);
        logic signed [P_W-1:0] biased;
        logic signed [P_W-1:0] shifted;
        biased  = p + (p[P_W-1] ? HALF_LO : HALF);
        shifted = biased >>> DROP;
        if (shifted > QMAX_P) begin
            return QMAX_P[OUT_W-1:0];
        end else if (shifted < QMIN_P) begin
            return QMIN_P[OUT_W-1:0];
        end
        return shifted[OUT_W-1:0];
    endfunction

    always_comb begin
        logic signed [GAIN_W:0] g_s;
        st_d = st_q;
        g_s = $signed({1'b0, gain});
        st_d.p_re = P_W'(d_re) * P_W'(g_s);
        st_d.p_im = P_W'(d_im) * P_W'(g_s);
        st_d.o_re = stg2_vld ? requant(st_q.p_re) : '0;
        st_d.o_im = stg2_vld ? requant(st_q.p_im) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_re = st_q.o_re;
    assign q_im = st_q.o_im;
endmodule

// File: rtl/gq_requant.sv
module gq_requant
    import gq_pkg::*;
#(
    parameter int NCHAN     = 4096,
    parameter int IN_W      = 18,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 4,
    parameter int OUT_FRAC  = 3,
    localparam int PAIRS    = NCHAN / 2,
    localparam int PAW      = $clog2(PAIRS),
    localparam int CAW      = $clog2(NCHAN),
    localparam int DROP     = (IN_W - 1) + GAIN_FRAC - OUT_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sync,
    input  logic signed [IN_W-1:0]  in_even_re,
    input  logic signed [IN_W-1:0]  in_even_im,
    input  logic signed [IN_W-1:0]  in_odd_re,
    input  logic signed [IN_W-1:0]  in_odd_im,
    input  logic                    cfg_we,
    input  logic [CAW-1:0]          cfg_addr,
    input  logic [GAIN_W-1:0]       cfg_wdata,
    output logic                    out_valid,
    output logic                    out_sync,
    output logic signed [OUT_W-1:0] out_even_re,
    output logic signed [OUT_W-1:0] out_even_im,
    output logic signed [OUT_W-1:0] out_odd_re,
    output logic signed [OUT_W-1:0] out_odd_im
);
    typedef struct packed {
        logic v1, y1, v2, y2, v3, y3;
        logic [NUM_LANES-1:0][IN_W-1:0] re1;
        logic [NUM_LANES-1:0][IN_W-1:0] im1;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PAW-1:0]          rd_idx;
    logic [GAIN_W-1:0]       gain [NUM_LANES];
    logic signed [OUT_W-1:0] q_re [NUM_LANES];
    logic signed [OUT_W-1:0] q_im [NUM_LANES];

    gq_pair_ctr #(.PAIRS(PAIRS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .rd_idx   (rd_idx)
    );

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.v1 = in_valid;
        pipe_d.y1 = in_valid && in_sync;
        pipe_d.re1[LANE_EVEN] = in_even_re;
        pipe_d.im1[LANE_EVEN] = in_even_im;
        pipe_d.re1[LANE_ODD]  = in_odd_re;
        pipe_d.im1[LANE_ODD]  = in_odd_im;
        pipe_d.v2 = pipe_q.v1;
        pipe_d.y2 = pipe_q.y1;
        pipe_d.v3 = pipe_q.v2;
        pipe_d.y3 = pipe_q.y2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic lane_we;
        assign lane_we = cfg_we && (cfg_addr[0] == lane_e'(i));

        gq_gain_ram #(.DEPTH(PAIRS), .W(GAIN_W)) u_ram (
            .clk   (clk),
            .we    (lane_we),
            .waddr (cfg_addr[CAW-1:1]),
            .wdata (cfg_wdata),
            .raddr (rd_idx),
            .rdata (gain[i])
        );

        gq_lane #(
            .IN_W   (IN_W),
            .GAIN_W (GAIN_W),
            .DROP   (DROP),
            .OUT_W  (OUT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .stg2_vld (pipe_q.v2),
            .d_re     (pipe_q.re1[i]),
            .d_im     (pipe_q.im1[i]),
            .gain     (gain[i]),
            .q_re     (q_re[i]),
            .q_im     (q_im[i])
        );
    end

    assign out_valid   = pipe_q.v3;
    assign out_sync    = pipe_q.y3;
    assign out_even_re = q_re[LANE_EVEN];
    assign out_even_im = q_im[LANE_EVEN];
    assign out_odd_re  = q_re[LANE_ODD];
    assign out_odd_im  = q_im[LANE_ODD];
endmodule

// File: rtl/gq_checker.sv
module gq_checker #(
    parameter int OUT_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sync,
    input logic                    out_valid,
    input logic                    out_sync,
    input logic signed [OUT_W-1:0] out_even_re,
    input logic signed [OUT_W-1:0] out_even_im,
    input logic signed [OUT_W-1:0] out_odd_re,
    input logic signed [OUT_W-1:0] out_odd_im
);
    localparam logic signed [OUT_W-1:0] MINCODE = {1'b1, {(OUT_W-1){1'b0}}};

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_sync == $past(in_valid && in_sync, 3)));

    a_r7_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_even_re != MINCODE && out_even_im != MINCODE &&
                       out_odd_re  != MINCODE && out_odd_im  != MINCODE));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_even_re == '0 && out_even_im == '0 &&
                        out_odd_re  == '0 && out_odd_im  == '0));

    a_r2_sync_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |-> out_valid);
endmodule

bind gq_requant gq_checker #(.OUT_W(OUT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sync     (in_sync),
    .out_valid   (out_valid),
    .out_sync    (out_sync),
    .out_even_re (out_even_re),
    .out_even_im (out_even_im),
    .out_odd_re  (out_odd_re),
    .out_odd_im  (out_odd_im)
);

// File: tb/tb_gq_requant.sv
module tb_gq_requant;
    localparam int NCHAN = 32;
    localparam int PAIRS = NCHAN / 2;
    localparam int IN_W  = 18;
    localparam int GW    = 16;
    localparam int OW    = 4;
    localparam int CAW   = $clog2(NCHAN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sync = 1'b0;
    logic signed [IN_W-1:0] in_even_re = '0, in_even_im = '0, in_odd_re = '0, in_odd_im = '0;
    logic cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [GW-1:0] cfg_wdata = '0;
    logic out_valid, out_sync;
    logic signed [OW-1:0] out_even_re, out_even_im, out_odd_re, out_odd_im;

    always #2.5 clk = ~clk;

    gq_requant #(.NCHAN(NCHAN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_even_re(in_even_re), .in_even_im(in_even_im),
        .in_odd_re(in_odd_re), .in_odd_im(in_odd_im),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_sync(out_sync),
        .out_even_re(out_even_re), .out_even_im(out_even_im),
        .out_odd_re(out_odd_re), .out_odd_im(out_odd_im)
    );

    typedef struct {
        int    cyc;
        bit    sy;
        int    er, ei, orr, oi;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    pidx = PAIRS - 1;
    int    gmodel[NCHAN];
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // R5, R6, R7: nearest step by magnitude, ties away from zero, clamp at 7
    function automatic int qexp(input int d, input int g);
        longint p, m, r;
        p = longint'(d) * longint'(g);
        m = (p < 0) ? -p : p;
        r = (m + (longint'(1) << 21)) >> 22;
        if (r > 7) r = 7;
        return (p < 0) ? -int'(r) : int'(r);
    endfunction

    function automatic int pat(input int k, input int lane);
        return ((k * 7919 + lane * 104729 + 12345) % 262144) - 131072;
    endfunction

    task automatic write_gain(input int ch, input int g);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = CAW'(ch);
        cfg_wdata = GW'(g);
        gmodel[ch] = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input bit sy, input int er, input int ei, input int orr,
                         input int oi, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_sync = sy;
        in_even_re = IN_W'(er);
        in_even_im = IN_W'(ei);
        in_odd_re = IN_W'(orr);
        in_odd_im = IN_W'(oi);
        pidx = sy ? 0 : (pidx + 1) % PAIRS;
        e.cyc = cyc + 3;
        e.sy = sy;
        e.er = qexp(er, gmodel[2 * pidx]);
        e.ei = qexp(ei, gmodel[2 * pidx]);
        e.orr = qexp(orr, gmodel[2 * pidx + 1]);
        e.oi = qexp(oi, gmodel[2 * pidx + 1]);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sync = 1'b0;
        end
    endtask

    task automatic check_quiet(input string tag);
        n_cmp++;
        if (out_valid !== 1'b0 || out_sync !== 1'b0 || out_even_re !== '0 ||
            out_even_im !== '0 || out_odd_re !== '0 || out_odd_im !== '0) begin
            n_bad++;
            $display("FAIL %s: valid=%0b sync=%0b data=%0d,%0d,%0d,%0d expected all 0",
                     tag, out_valid, out_sync, out_even_re, out_even_im, out_odd_re, out_odd_im);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2: unexpected output at cycle %0d, expected none", cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    n_cmp++;
                    if (e.cyc != cyc || e.sy != out_sync || e.er != int'(out_even_re) ||
                        e.ei != int'(out_even_im) || e.orr != int'(out_odd_re) ||
                        e.oi != int'(out_odd_im)) begin
                        n_bad++;
                        $display("FAIL %s: cyc=%0d sync=%0b data=%0d,%0d,%0d,%0d expected cyc=%0d sync=%0b data=%0d,%0d,%0d,%0d",
                                 e.tag, cyc, out_sync, out_even_re, out_even_im, out_odd_re,
                                 out_odd_im, e.cyc, e.sy, e.er, e.ei, e.orr, e.oi);
                    end
                end
            end else if (sb.size() != 0 && sb[0].cyc < cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++; n_bad++;
                $display("FAIL R2 (%s): no output at cycle %0d, expected valid at cycle %0d",
                         e.tag, cyc, e.cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_quiet("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R4: distinct gains per channel; channels 0..3 at unity for tie tests
        for (int ch = 0; ch < NCHAN; ch++) begin
            write_gain(ch, (ch < 4) ? 256 : 64 + ch * 40);
        end

        // Frame A: ties (R6), clamp (R7), distinct channel gains (R4, R9)
        drive(1'b1, 8192, -8192, 24576, -24576, "R6 ties at +-0.5 and +-1.5");
        drive(1'b0, 8191, -8191, 131071, -131072, "R7 clamp and near-tie");
        for (int k = 2; k < PAIRS; k++) begin
            drive(1'b0, pat(k, 0), pat(k, 1), pat(k, 2), pat(k, 3), "R5 R9 frame A");
        end
        idle(6);
        check_quiet("R10 idle outputs");

        // Frame B with valid gaps (R3), then wrap without sync
        for (int k = 0; k < PAIRS + 4; k++) begin
            drive(k == 0, pat(k + 40, 2), pat(k + 40, 3), pat(k + 40, 0),
                  pat(k + 40, 1), (k >= PAIRS) ? "R3 wrap" : "R3 gaps");
            if (k % 3 == 1) idle(1);
        end

        // sync in mid-frame restarts at pair 0 (R3)
        for (int k = 0; k < 5; k++) begin
            drive(k == 3, 131071 - k * 9000, -131072 + k * 7000, 65536, -65536, "R3 mid-frame sync");
        end
        idle(6);

        // R8: rewrite gains while idle; new values must govern the next frame
        write_gain(0, 0);
        write_gain(1, 65535);
        write_gain(2, 128);
        write_gain(3, 512);
        drive(1'b1, 131071, -131072, 300, -300, "R8 new gains pair 0");
        drive(1'b0, 12288, -12288, 12288, -12288, "R8 new gains pair 1 ties");
        drive(1'b0, pat(7, 0), pat(7, 1), pat(7, 2), pat(7, 3), "R8 untouched pair 2");
        idle(8);
        check_quiet("R10 drained");

        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d results never appeared, expected 0", sb.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule